// File: doc/BRIEF.md
# Configurable SPI Slave Controller

This block is the slave side of a four-wire serial peripheral link. A host on the system-clock side programs it through a small register port. The registers are a configuration byte, a status word with write-one-to-clear flags, a data location and a spare clock-divider byte. The serial pins SCK, MOSI and the select line are brought into the system clock domain through a synchroniser. Edges of SCK are detected there, and the reply is shifted out on MISO. The system clock must run at least four times as fast as SCK.

Each transfer carries one character of 8 or 16 bits, most significant bit first. Software picks the clock polarity, the clock phase and the level at which the select line counts as active. Transmit and receive data are held in separate registers that share one address. A write loads the next reply. A read returns the last character that was received. Four event flags report completion, overrun, a write collision and a select that dropped mid-character. One enable bit gates these flags onto a single interrupt request.

Top module: `spi_slave_ctl`

## Requirements
- R1: After reset, all four register locations read 0 and `irq` is 0. The locations are configuration at address 0, status at 1, data at 2 and clock divider at 3.
- R2: In the configuration byte, bit 7 is interrupt enable, bit 6 is the select active level, bit 2 is the character length, bit 1 is the phase and bit 0 is the polarity. Bits 5:3 always read 0, whatever is written to them.
- R3: The clock-divider byte reads back the value last written to it and has no influence on transfers.
- R4: Received bits are assembled MSB first. With polarity 0 the active SCK edge is the rising edge, and with polarity 1 it is the falling edge. With phase 0 MOSI is sampled on the active edge, and with phase 1 on the inactive edge.
- R5: MISO presents the transmit word MSB first in every mode. The first bit is valid before the first sampling edge, and each following bit is shifted out on the edge that is not the sampling edge.
- R6: When the length bit is 0 the character is 8 bits: only bits 7:0 of the transmit word are sent, and bits 15:8 of the received data read 0. When the length bit is 1 all 16 bits are used.
- R7: The select line counts as active when it is low if the level bit is 0, and when it is high if the level bit is 1. SCK activity while the select is inactive sets no flag and changes no data.
- R8: Status bit 0 (done) is set when a full character has been received.
- R9: A data write while the select is active is discarded and sets status bit 2 (collision). Status bit 4 reads 1 while the select is active.
- R10: A character that completes while the previous one is still unread sets status bit 1 (overrun) and replaces the old data. Reading the data location marks the character as read.
- R11: If the select goes inactive in the middle of a character, status bit 3 (mode fault) is set and the partial character is dropped.
- R12: `irq` is 1 exactly when the enable bit is 1 and any of status bits 3:0 is set. Writing 1 to a status bit clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used to mark receive data as read) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | WORD_W | Register write data |
| reg_rdata | output | WORD_W | Register read data, combinational on address |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| ss | input | 1 | Slave select, active level programmable |
| miso | output | 1 | Serial data to the master |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit data word and a two-stage synchroniser. With these values both character lengths can be tested, along with all four polarity and phase combinations and both select levels. The serial clock runs with an eight-cycle half period, which keeps SCK, MOSI and the select well inside the synchroniser's latency margin. With this timing, mid-character deselects, collisions during an active select and back-to-back unread characters can all be produced with exact, known cycle timing.

// File: rtl/spi_slv_pkg.sv
`timescale 1ns/1ps
package spi_slv_pkg;
   localparam logic [1:0] A_CFG  = 2'd0;
   localparam logic [1:0] A_STAT = 2'd1;
   localparam logic [1:0] A_DATA = 2'd2;
   localparam logic [1:0] A_CKD  = 2'd3;

   localparam int CF_IE   = 7;
   localparam int CF_LVL  = 6;
   localparam int CF_LEN  = 2;
   localparam int CF_PHA  = 1;
   localparam int CF_POL  = 0;
   localparam logic [7:0] CF_MASK = 8'hC7;

   localparam int ST_DONE = 0;
   localparam int ST_OVR  = 1;
   localparam int ST_WCOL = 2;
   localparam int ST_MF   = 3;
   localparam int NFLAGS  = 4;
endpackage

// File: rtl/spi_slv_sync.sv
`timescale 1ns/1ps
module spi_slv_sync #(
   parameter int         STAGES  = 2,
   parameter int         W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_slv_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_slv_shift.sv
`timescale 1ns/1ps
module spi_slv_shift #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              mosi_s,
   input  logic              sel,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              wide,
   input  logic [WORD_W-1:0] tx_word,
   output logic              miso,
   output logic              done,
   output logic              mfault,
   output logic [WORD_W-1:0] rx_word
);
   localparam int HALF = WORD_W / 2;
   localparam int CW   = $clog2(WORD_W);
   localparam logic [CW-1:0] LAST_W = CW'(WORD_W - 1);
   localparam logic [CW-1:0] LAST_H = CW'(HALF - 1);

   logic              sck_q, sel_q, skip;
   logic [CW-1:0]     cnt;
   logic [WORD_W-1:0] tx_sh, rx_sh, rx_next, load_val;
   logic              rise, fall, act, inact, smp, drv;
   logic [CW-1:0]     last;

   assign rise     = sck_s & ~sck_q;
   assign fall     = ~sck_s & sck_q;
   assign act      = cpol ? fall : rise;
   assign inact    = cpol ? rise : fall;
   assign smp      = cpha ? inact : act;
   assign drv      = cpha ? act : inact;
   assign last     = wide ? LAST_W : LAST_H;
   assign rx_next  = {rx_sh[WORD_W-2:0], mosi_s};
   assign load_val = wide ? tx_word : {{(WORD_W-HALF){1'b0}}, tx_word[HALF-1:0]};
   assign miso     = wide ? tx_sh[WORD_W-1] : tx_sh[HALF-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q   <= 1'b0;
         sel_q   <= 1'b0;
         skip    <= 1'b0;
         cnt     <= '0;
         tx_sh   <= '0;
         rx_sh   <= '0;
         rx_word <= '0;
         done    <= 1'b0;
         mfault  <= 1'b0;
      end else begin
         sck_q  <= sck_s;
         sel_q  <= sel;
         done   <= 1'b0;
         mfault <= 1'b0;
         if (!sel) begin
            cnt <= '0;
            if (sel_q && cnt != '0) mfault <= 1'b1;
         end else if (!sel_q) begin
            tx_sh <= load_val;
            skip  <= cpha;
            cnt   <= '0;
         end else if (smp) begin
            rx_sh <= rx_next;
            if (cnt == last) begin
               cnt     <= '0;
               done    <= 1'b1;
               rx_word <= wide ? rx_next
                               : {{(WORD_W-HALF){1'b0}}, rx_next[HALF-1:0]};
               tx_sh   <= load_val;
               skip    <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else if (drv) begin
            if (skip) skip  <= 1'b0;
            else      tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
         end
      end
   end
endmodule

// File: rtl/spi_slave_ctl.sv
`timescale 1ns/1ps
module spi_slave_ctl
   import spi_slv_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   input  logic              sck,
   input  logic              mosi,
   input  logic              ss,
   output logic              miso,
   output logic              irq
);
   generate
      if (WORD_W < 8 || (WORD_W % 2) != 0) begin : g_bad_width
         $error("spi_slave_ctl: WORD_W must be even and at least 8");
      end
   endgenerate

   logic [7:0]        cfg_q, ckd_q;
   logic [WORD_W-1:0] tx_q, rx_word;
   logic [NFLAGS-1:0] flags, fl_set, fl_clr;
   logic              rx_full, sel, sh_done, mfault;
   logic              sck_s, mosi_s, ss_s;
   logic              wr_data, wr_stat;

   spi_slv_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({ss, mosi, sck}),
      .q({ss_s, mosi_s, sck_s})
   );

   assign sel = cfg_q[CF_LVL] ? ss_s : ~ss_s;

   spi_slv_shift #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .sck_s(sck_s), .mosi_s(mosi_s), .sel(sel),
      .cpol(cfg_q[CF_POL]), .cpha(cfg_q[CF_PHA]), .wide(cfg_q[CF_LEN]),
      .tx_word(tx_q), .miso(miso), .done(sh_done), .mfault(mfault),
      .rx_word(rx_word)
   );

   assign wr_data = reg_wr && reg_addr == A_DATA;
   assign wr_stat = reg_wr && reg_addr == A_STAT;

   always_comb begin
      fl_set          = '0;
      fl_set[ST_DONE] = sh_done;
      fl_set[ST_OVR]  = sh_done & rx_full;
      fl_set[ST_WCOL] = wr_data & sel;
      fl_set[ST_MF]   = mfault;
      fl_clr          = wr_stat ? reg_wdata[NFLAGS-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         ckd_q   <= '0;
         tx_q    <= '0;
         flags   <= '0;
         rx_full <= 1'b0;
      end else begin
         if (reg_wr && reg_addr == A_CFG) cfg_q <= reg_wdata[7:0] & CF_MASK;
         if (reg_wr && reg_addr == A_CKD) ckd_q <= reg_wdata[7:0];
         if (wr_data && !sel)             tx_q  <= reg_wdata;
         flags <= (flags & ~fl_clr) | fl_set;
         if (sh_done)                               rx_full <= 1'b1;
         else if (reg_rd && reg_addr == A_DATA)     rx_full <= 1'b0;
      end
   end

   always_comb begin
      case (reg_addr)
         A_CFG:   reg_rdata = WORD_W'(cfg_q);
         A_STAT:  reg_rdata = WORD_W'({sel, flags});
         A_DATA:  reg_rdata = rx_word;
         default: reg_rdata = WORD_W'(ckd_q);
      endcase
   end

   assign irq = cfg_q[CF_IE] & (|flags);
endmodule

// File: rtl/spi_slave_ctl_chk.sv
`timescale 1ns/1ps
module spi_slave_ctl_chk
   import spi_slv_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [1:0]        reg_addr,
   input logic              sel,
   input logic [WORD_W-1:0] tx_q,
   input logic [NFLAGS-1:0] flags,
   input logic [7:0]        cfg_q,
   input logic              sh_done,
   input logic              rx_full,
   input logic              mfault,
   input logic [WORD_W-1:0] rx_word,
   input logic              irq
);
   p_cfg_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[5:3] == 3'b000);

   p_done_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sh_done |=> flags[ST_DONE]);

   p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_done && !cfg_q[CF_LEN] && $stable(cfg_q[CF_LEN]))
         |-> rx_word[WORD_W-1:WORD_W/2] == '0);

   p_wcol_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_DATA && sel) |=> flags[ST_WCOL]);

   p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_DATA && sel) |=> $stable(tx_q));

   p_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_done && rx_full) |=> flags[ST_OVR]);

   p_mfault_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mfault |=> flags[ST_MF]);

   p_irq_enable_r12: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> cfg_q[CF_IE]);
endmodule

bind spi_slave_ctl spi_slave_ctl_chk #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .sel(sel), .tx_q(tx_q), .flags(flags), .cfg_q(cfg_q),
   .sh_done(sh_done), .rx_full(rx_full), .mfault(mfault),
   .rx_word(rx_word), .irq(irq)
);

// File: tb/spi_slave_ctl_bench.sv
`timescale 1ns/1ps
module spi_slave_ctl_bench;
   localparam int H = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        sck = 1'b0, mosi = 1'b0, ss = 1'b1;
   logic        miso, irq;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   spi_slave_ctl u_spi_slave_ctl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sck(sck), .mosi(mosi), .ss(ss), .miso(miso), .irq(irq)
   );

   // {cpol, cpha, len, lvl, tx[15:0], mosi[15:0]}
   localparam logic [35:0] VEC [8] = '{
      {4'b0000, 16'h12A5, 16'hFF3C},
      {4'b0100, 16'h7781, 16'h55C3},
      {4'b1001, 16'hEE5A, 16'h99F0},
      {4'b1101, 16'h00E7, 16'hAA0F},
      {4'b0010, 16'hBEEF, 16'h1234},
      {4'b0111, 16'h8001, 16'hCAFE},
      {4'b1010, 16'h7FFE, 16'h9ABC},
      {4'b1111, 16'hF00D, 16'h5AA5}
   };

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic setup(input logic [7:0] c, input logic ss_idle, input logic cp);
      wr(2'd0, {8'h00, c});
      ss = ss_idle; sck = cp;
      repeat (6) @(negedge clk);
      wr(2'd1, 16'h000F);
   endtask

   task automatic xfer(input logic cp, input logic ph, input int nb, input int len,
                       input logic [15:0] mo, input logic ss_on, input logic ss_off,
                       output logic [15:0] mi);
      mi = '0;
      @(negedge clk);
      sck = cp; ss = ss_on;
      repeat (H) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
         if (!ph) begin
            mosi = mo[len-1-i];
            repeat (H) @(negedge clk);
            mi = {mi[14:0], miso};
            sck = ~cp;
            repeat (H) @(negedge clk);
            sck = cp;
         end else begin
            sck = ~cp;
            mosi = mo[len-1-i];
            repeat (H) @(negedge clk);
            mi = {mi[14:0], miso};
            sck = cp;
            repeat (H) @(negedge clk);
         end
      end
      repeat (H) @(negedge clk);
      ss = ss_off;
      repeat (6) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      logic [15:0] d, mi, last_rx;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1 reset values
      rd(2'd0, d); chk("R1 cfg", d, 16'h0000);
      rd(2'd1, d); chk("R1 status", d, 16'h0000);
      rd(2'd2, d); chk("R1 data", d, 16'h0000);
      rd(2'd3, d); chk("R1 clkdiv", d, 16'h0000);
      chk("R1 irq", {15'h0, irq}, 16'h0000);

      // R2 reserved bits
      wr(2'd0, 16'h00FF); rd(2'd0, d); chk("R2 cfg mask", d, 16'h00C7);
      ss = 1'b0; // with lvl=1 this is inactive
      wr(2'd0, 16'h0000); ss = 1'b1;
      repeat (6) @(negedge clk);
      wr(2'd1, 16'h000F);

      // R3 clock divider read back
      wr(2'd3, 16'h005A); rd(2'd3, d); chk("R3 clkdiv", d, 16'h005A);

      last_rx = '0;
      for (int v = 0; v < 8; v++) begin
         logic cp, ph, ln, lv;
         logic [15:0] tx, mo, erx, etx;
         {cp, ph, ln, lv, tx, mo} = VEC[v];
         setup({1'b0, lv, 3'b000, ln, ph, cp}, ~lv, cp);
         wr(2'd2, tx);
         xfer(cp, ph, ln ? 16 : 8, ln ? 16 : 8, mo, lv, ~lv, mi);
         erx = ln ? mo : {8'h00, mo[7:0]};
         etx = ln ? tx : {8'h00, tx[7:0]};
         rd(2'd2, d);
         if (ln) chk("R4 rx word", d, erx);
         else    chk("R6 rx byte", d, erx);
         chk("R5 miso word", mi, etx);
         rd(2'd1, d); chk("R8 done flag", d, 16'h0001);
         last_rx = erx;
      end

      // R7 inactive select level ignores clocks
      setup(8'h40, 1'b0, 1'b0);
      xfer(1'b0, 1'b0, 8, 8, 16'h0081, 1'b0, 1'b0, mi);
      rd(2'd1, d); chk("R7 status", d, 16'h0000);
      rd(2'd2, d); chk("R7 data", d, last_rx);

      // R9 write collision
      setup(8'h00, 1'b1, 1'b0);
      wr(2'd2, 16'h003C);
      ss = 1'b0;
      repeat (6) @(negedge clk);
      wr(2'd2, 16'h00FF);
      rd(2'd1, d); chk("R9 busy+wcol", d, 16'h0014);
      xfer(1'b0, 1'b0, 8, 8, 16'h0011, 1'b0, 1'b1, mi);
      chk("R9 tx kept", mi, 16'h003C);
      rd(2'd2, d);

      // R10 overrun
      setup(8'h00, 1'b1, 1'b0);
      xfer(1'b0, 1'b0, 8, 8, 16'h0011, 1'b0, 1'b1, mi);
      xfer(1'b0, 1'b0, 8, 8, 16'h0022, 1'b0, 1'b1, mi);
      rd(2'd1, d); chk("R10 overrun", d, 16'h0003);
      rd(2'd2, d); chk("R10 newest", d, 16'h0022);

      // R11 mode fault
      setup(8'h00, 1'b1, 1'b0);
      xfer(1'b0, 1'b0, 3, 8, 16'h00E0, 1'b0, 1'b1, mi);
      rd(2'd1, d); chk("R11 mfault", d, 16'h0008);
      wr(2'd1, 16'h000F);
      xfer(1'b0, 1'b0, 8, 8, 16'h006D, 1'b0, 1'b1, mi);
      rd(2'd2, d); chk("R11 clean char", d, 16'h006D);

      // R12 interrupt gating and clear
      #1 chk("R12 irq gated", {15'h0, irq}, 16'h0000);
      wr(2'd0, 16'h0080);
      #1 chk("R12 irq on", {15'h0, irq}, 16'h0001);
      wr(2'd1, 16'h000F);
      #1 chk("R12 irq clear", {15'h0, irq}, 16'h0000);
      rd(2'd1, d); chk("R12 status clear", d, 16'h0000);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule